// File: doc/BRIEF.md
# Capture/Compare Timer-Counter

This block is a 16-bit timer/counter with a small register port. It can run as one 16-bit count or be split into two 8-bit halves. Its mode comes from three control fields: a timer/counter source bit, a two-bit edge selector and an edge-action bit. Together they give four behaviours. The block can be a free-running timer that flags a compare match. It can be a timer that captures its count, or reloads it, when a chosen pin edge arrives. It can be an edge counter that advances on chosen pin transitions. It can also be disabled. When the count passes its maximum, it reloads from a shared reload/capture register and raises an overflow flag. A single interrupt line reports any pending flag, gated by a local enable.

The input pin is untimed. It passes through a two-flop synchronizer and a one-flop history stage before edge detection. Software programs the block through a plain write strobe with an address and data. It reads through a combinational read mux addressed by the same lines. There is no streaming data path, so the port has no valid/ready handshake. A write completes in the cycle it is presented and cannot be held off.

Register map (address: contents):
- 0, CTRL: bit0 RUN, bit1 RUN_LO, bit2 SRC, bits 4:3 EDGE, bit5 SPLIT, bit6 IE, bit7 RLD.
- 1, STAT: bit0 OVF, bit1 CCF, bit2 OVF_LO, bit3 CCF_LO.
- 2, COUNT.
- 3, RCAP (the shared reload/capture register).
- 4, CMP.
- Any other address reads 0.

Top module: `cc_timer`

## Requirements
- R1: After reset every register reads 0. CTRL bits 15:8 always read 0, and writes to those bits have no effect.
- R2: EDGE selects the pin event: 00 none, 01 rising, 10 falling, 11 both. A pin change driven before clock edge k takes effect on clock edge k+2.
- R3: With SRC=0 and EDGE=00 (compare mode) and RUN=1, COUNT increments once per clock. CCF is set when COUNT equals CMP.
- R4: When a running count steps from all ones, COUNT loads RCAP instead of wrapping to zero, and OVF is set.
- R5: With SRC=0, EDGE nonzero, RLD=0 and RUN=1, the count keeps running. Each selected edge copies the current COUNT into RCAP and sets CCF.
- R6: With SRC=0, EDGE nonzero, RLD=1 and RUN=1, a selected edge loads COUNT from RCAP instead of incrementing that cycle, and sets CCF.
- R7: With SRC=1, EDGE nonzero and RUN=1, COUNT increments once per selected pin edge and at no other time.
- R8: With SRC=1 and EDGE=00, COUNT holds regardless of the pin.
- R9: With RUN=0 and SPLIT=0, COUNT holds and no flag is raised.
- R10: Flags are sticky. Writing STAT clears each bit written as 0 and keeps each bit written as 1. A hardware set in the same cycle wins over the clear.
- R11: irq is high exactly when IE=1 and at least one STAT flag is set.
- R12: With SPLIT=1, the low byte is a compare-only timer. It runs while RUN_LO=1, compares with CMP[7:0], reloads from RCAP[7:0], and sets OVF_LO and CCF_LO; the pin never affects it. The high byte follows SRC, EDGE, RLD and RUN as an 8-bit count. It uses CMP[15:8], reloads from RCAP[15:8], captures into RCAP[15:8], and sets OVF and CCF.
- R13: A software write to COUNT or RCAP takes priority over any hardware update of that register in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register address for write and read |
| reg_wdata | input | 16 | Write data |
| reg_rdata | output | 16 | Read data for reg_addr (combinational) |
| pin_in | input | 1 | Asynchronous event pin |
| irq | output | 1 | Interrupt request |

## Verification
The bench targets the places where the count source, the reload and the flags meet.
- A capture that lands on the overflow cycle must store the pre-reload count while the reload uses the old RCAP; a design that ordered these wrongly would reload with the value it had just captured.
- A reload edge must replace that cycle's increment; a design that got this wrong would land one count high.
- Both-edge counting must count every transition, and edge 00 in counter mode must freeze the count; a wrong edge decode would count half the toggles or keep counting.
- In split mode the pin is toggled while the low byte runs, and a leaked carry or pin path would disturb the low byte or the high byte.
- Flag clears that race a hardware set are exercised; a design that let the clear win would lose an event.

// File: rtl/cc_timer_pkg.sv
package cc_timer_pkg;

  localparam logic [2:0] ADR_CTRL  = 3'd0;
  localparam logic [2:0] ADR_STAT  = 3'd1;
  localparam logic [2:0] ADR_COUNT = 3'd2;
  localparam logic [2:0] ADR_RCAP  = 3'd3;
  localparam logic [2:0] ADR_CMP   = 3'd4;

  localparam int unsigned CTRL_BITS = 8;
  localparam int unsigned STAT_BITS = 4;

  typedef struct packed {
    logic       rld;
    logic       ie;
    logic       split;
    logic [1:0] edge_sel;
    logic       src;
    logic       run_lo;
    logic       run;
  } ctrl_t;

  typedef enum logic [1:0] {
    M_COMPARE = 2'd0,
    M_CAPTURE = 2'd1,
    M_COUNT   = 2'd2,
    M_OFF     = 2'd3
  } mode_e;

  function automatic mode_e decode_mode(input logic src, input logic [1:0] es);
    if (!src) return (es == 2'b00) ? M_COMPARE : M_CAPTURE;
    return (es == 2'b00) ? M_OFF : M_COUNT;
  endfunction

endpackage

// File: rtl/cc_timer_edge.sv
module cc_timer_edge #(
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       pin,
  input  logic [1:0] edge_sel,
  output logic       evt
);
  localparam int unsigned TAP = SYNC_STAGES - 1;

  logic [SYNC_STAGES-1:0] sync_q;
  logic                   last_q;
  logic                   rise, fall;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= '0;
      last_q <= 1'b0;
    end else begin
      sync_q <= {sync_q[SYNC_STAGES-2:0], pin};
      last_q <= sync_q[TAP];
    end
  end

  always_comb begin
    rise = sync_q[TAP] & ~last_q;
    fall = ~sync_q[TAP] & last_q;
    evt  = (edge_sel[0] & rise) | (edge_sel[1] & fall);
  end

  // R2: a rising-only selection can only fire on a high sample
  p_rise_high_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (evt && !edge_sel[1]) |-> sync_q[TAP]);

  // R2: a falling-only selection can only fire on a low sample
  p_fall_low_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (evt && !edge_sel[0]) |-> !sync_q[TAP]);

endmodule

// File: rtl/cc_timer_lane.sv
module cc_timer_lane #(
  parameter int unsigned LW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          sw_we,
  input  logic [LW-1:0] sw_val,
  input  logic          hw_load,
  input  logic [LW-1:0] hw_val,
  input  logic          step,
  output logic [LW-1:0] cnt,
  output logic          at_max
);
  logic [LW-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       cnt_q <= '0;
    else if (sw_we)   cnt_q <= sw_val;
    else if (hw_load) cnt_q <= hw_val;
    else if (step)    cnt_q <= cnt_q + 1'b1;
  end

  assign cnt    = cnt_q;
  assign at_max = &cnt_q;

  // R13: software write wins over any hardware update
  p_sw_load_r13: assert property (@(posedge clk) disable iff (!rst_n)
    sw_we |=> (cnt_q == $past(sw_val)));

  // R3: a plain step advances by one
  p_step_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (!sw_we && !hw_load && step && !at_max) |=> (cnt_q == $past(cnt_q) + 1'b1));

  // R9: no request leaves the lane untouched
  p_idle_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (!sw_we && !hw_load && !step) |=> $stable(cnt_q));

endmodule

// File: rtl/cc_timer.sv
module cc_timer
  import cc_timer_pkg::*;
#(
  parameter int unsigned CW          = 16,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          reg_wr,
  input  logic [2:0]    reg_addr,
  input  logic [CW-1:0] reg_wdata,
  output logic [CW-1:0] reg_rdata,
  input  logic          pin_in,
  output logic          irq
);
  localparam int unsigned HW     = CW / 2;
  localparam int unsigned LANES  = 2;

  ctrl_t               ctrl_q;
  logic [STAT_BITS-1:0] stat_q, stat_set;
  logic [CW-1:0]        rcap_q, cmp_q;

  logic ctrl_wr, stat_wr, cnt_wr, rcap_wr, cmp_wr;
  logic evt;
  mode_e mode;

  logic [LANES-1:0] ln_step, ln_load, ln_max;
  logic [HW-1:0]    ln_cnt  [LANES];
  logic [HW-1:0]    ln_hval [LANES];
  logic [CW-1:0]    cnt_full;
  logic [HW-1:0]    cnt_lo, cnt_hi;

  logic main_evt, main_act_edge, main_rld_edge, main_cap_edge;
  logic main_step, main_max, main_match, main_ovf, main_ccf;
  logic lo_step, lo_ovf, lo_ccf;

  // register decode
  always_comb begin
    ctrl_wr = reg_wr && (reg_addr == ADR_CTRL);
    stat_wr = reg_wr && (reg_addr == ADR_STAT);
    cnt_wr  = reg_wr && (reg_addr == ADR_COUNT);
    rcap_wr = reg_wr && (reg_addr == ADR_RCAP);
    cmp_wr  = reg_wr && (reg_addr == ADR_CMP);
  end

  cc_timer_edge #(.SYNC_STAGES(SYNC_STAGES)) u_edge (
    .clk      (clk),
    .rst_n    (rst_n),
    .pin      (pin_in),
    .edge_sel (ctrl_q.edge_sel),
    .evt      (evt)
  );

  assign mode     = decode_mode(ctrl_q.src, ctrl_q.edge_sel);
  assign cnt_lo   = ln_cnt[0];
  assign cnt_hi   = ln_cnt[1];
  assign cnt_full = {cnt_hi, cnt_lo};

  // main (16-bit or high-half) sequencing
  always_comb begin
    main_evt      = ctrl_q.run & evt;
    main_act_edge = main_evt & (mode == M_CAPTURE);
    main_rld_edge = main_act_edge & ctrl_q.rld;
    main_cap_edge = main_act_edge & ~ctrl_q.rld;
    main_step     = ctrl_q.run & ((mode == M_COMPARE) |
                                  ((mode == M_CAPTURE) & ~main_rld_edge) |
                                  ((mode == M_COUNT) & evt));
    if (ctrl_q.split) begin
      main_max   = ln_max[1];
      main_match = (cnt_hi == cmp_q[CW-1:HW]);
    end else begin
      main_max   = ln_max[1] & ln_max[0];
      main_match = (cnt_full == cmp_q);
    end
    main_ovf = main_step & main_max;
    main_ccf = main_act_edge | (ctrl_q.run & (mode == M_COMPARE) & main_match);
  end

  // low-half compare-only timer in split mode
  always_comb begin
    lo_step = ctrl_q.split & ctrl_q.run_lo;
    lo_ovf  = lo_step & ln_max[0];
    lo_ccf  = lo_step & (cnt_lo == cmp_q[HW-1:0]);
  end

  // lane steering
  always_comb begin
    ln_step[1] = main_step & (ctrl_q.split | ln_max[0]);
    ln_load[1] = main_ovf | main_rld_edge;
    if (ctrl_q.split) begin
      ln_step[0] = lo_step;
      ln_load[0] = lo_ovf;
    end else begin
      ln_step[0] = main_step;
      ln_load[0] = main_ovf | main_rld_edge;
    end
  end

  for (genvar gi = 0; gi < LANES; gi++) begin : g_lane
    assign ln_hval[gi] = rcap_q[gi*HW +: HW];
    cc_timer_lane #(.LW(HW)) u_lane (
      .clk     (clk),
      .rst_n   (rst_n),
      .sw_we   (cnt_wr),
      .sw_val  (reg_wdata[gi*HW +: HW]),
      .hw_load (ln_load[gi]),
      .hw_val  (ln_hval[gi]),
      .step    (ln_step[gi]),
      .cnt     (ln_cnt[gi]),
      .at_max  (ln_max[gi])
    );
  end

  assign stat_set = {lo_ccf, lo_ovf, main_ccf, main_ovf};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q <= '0;
      stat_q <= '0;
      rcap_q <= '0;
      cmp_q  <= '0;
    end else begin
      if (ctrl_wr) ctrl_q <= ctrl_t'(reg_wdata[CTRL_BITS-1:0]);
      if (cmp_wr)  cmp_q  <= reg_wdata;
      stat_q <= (stat_wr ? (stat_q & reg_wdata[STAT_BITS-1:0]) : stat_q) | stat_set;
      if (rcap_wr)
        rcap_q <= reg_wdata;
      else if (main_cap_edge)
        rcap_q <= ctrl_q.split ? {cnt_hi, rcap_q[HW-1:0]} : cnt_full;
    end
  end

  always_comb begin
    reg_rdata = '0;
    case (reg_addr)
      ADR_CTRL:  reg_rdata[CTRL_BITS-1:0] = ctrl_q;
      ADR_STAT:  reg_rdata[STAT_BITS-1:0] = stat_q;
      ADR_COUNT: reg_rdata = cnt_full;
      ADR_RCAP:  reg_rdata = rcap_q;
      ADR_CMP:   reg_rdata = cmp_q;
      default:   reg_rdata = '0;
    endcase
  end

  assign irq = ctrl_q.ie & (|stat_q);

  // R1: upper control bits never read back
  p_ctrl_rsvd_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_addr == ADR_CTRL) |-> (reg_rdata[CW-1:CTRL_BITS] == '0));

  // R9: stopped full-width count holds
  p_run_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (!ctrl_q.run && !ctrl_q.split && !cnt_wr) |=> $stable(cnt_full));

  // R8: disabled counter mode holds
  p_off_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    ((mode == M_OFF) && !ctrl_q.split && !cnt_wr) |=> $stable(cnt_full));

  // R5: a capture stores the count seen on that edge
  p_capture_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (main_cap_edge && !ctrl_q.split && !rcap_wr) |=> (rcap_q == $past(cnt_full)));

  // R4: overflow reloads from the old reload value
  p_ovf_reload_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (main_ovf && !ctrl_q.split && !cnt_wr) |=> (cnt_full == $past(rcap_q)));

  // R10: flags never drop without a status write
  p_flag_sticky_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !stat_wr |=> ((stat_q & $past(stat_q)) == $past(stat_q)));

  // R12: split low half ignores everything but its own run bit
  p_lo_pinfree_r12: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl_q.split && !ctrl_q.run_lo && !cnt_wr) |=> $stable(cnt_lo));

endmodule

// File: tb/cc_timer_bench.sv
`timescale 1ns/1ps
module cc_timer_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_wr = 1'b0;
  logic [2:0]  reg_addr = 3'd2;
  logic [15:0] reg_wdata = '0;
  logic [15:0] reg_rdata;
  logic        pin_in = 1'b0;
  logic        irq;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;
  string phase = "R1";

  always #2 clk = ~clk;

  cc_timer u_cc_timer (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .pin_in(pin_in), .irq(irq)
  );

  // behavioural reference model
  logic [7:0]  m_ctrl;
  logic [3:0]  m_stat;
  logic [15:0] m_cnt, m_rcap, m_cmp;
  logic        m_s1, m_s2, m_s3;

  always @(posedge clk or negedge rst_n) begin : model
    logic evt, run, src, split, rld;
    logic [1:0] es;
    logic [3:0] set;
    logic [15:0] nc, nr;
    logic [7:0] hi, lo, nh, nl;
    if (!rst_n) begin
      m_ctrl <= '0; m_stat <= '0; m_cnt <= '0; m_rcap <= '0; m_cmp <= '0;
      m_s1 <= 1'b0; m_s2 <= 1'b0; m_s3 <= 1'b0;
    end else begin
      run = m_ctrl[0]; src = m_ctrl[2]; es = m_ctrl[4:3];
      split = m_ctrl[5]; rld = m_ctrl[7];
      evt = (es[0] && m_s2 && !m_s3) || (es[1] && !m_s2 && m_s3);
      nc = m_cnt; nr = m_rcap; set = '0;
      if (!split) begin
        if (run) begin
          if (!src && es == 2'b00) begin
            if (m_cnt == m_cmp) set[1] = 1'b1;
            if (m_cnt == 16'hFFFF) begin nc = m_rcap; set[0] = 1'b1; end
            else nc = m_cnt + 16'd1;
          end else if (!src) begin
            if (evt) begin
              set[1] = 1'b1;
              if (rld) nc = m_rcap; else nr = m_cnt;
            end
            if (!(evt && rld)) begin
              if (m_cnt == 16'hFFFF) begin nc = m_rcap; set[0] = 1'b1; end
              else nc = m_cnt + 16'd1;
            end
          end else if (es != 2'b00 && evt) begin
            if (m_cnt == 16'hFFFF) begin nc = m_rcap; set[0] = 1'b1; end
            else nc = m_cnt + 16'd1;
          end
        end
      end else begin
        hi = m_cnt[15:8]; lo = m_cnt[7:0]; nh = hi; nl = lo;
        if (run) begin
          if (!src && es == 2'b00) begin
            if (hi == m_cmp[15:8]) set[1] = 1'b1;
            if (hi == 8'hFF) begin nh = m_rcap[15:8]; set[0] = 1'b1; end
            else nh = hi + 8'd1;
          end else if (!src) begin
            if (evt) begin
              set[1] = 1'b1;
              if (rld) nh = m_rcap[15:8]; else nr[15:8] = hi;
            end
            if (!(evt && rld)) begin
              if (hi == 8'hFF) begin nh = m_rcap[15:8]; set[0] = 1'b1; end
              else nh = hi + 8'd1;
            end
          end else if (es != 2'b00 && evt) begin
            if (hi == 8'hFF) begin nh = m_rcap[15:8]; set[0] = 1'b1; end
            else nh = hi + 8'd1;
          end
        end
        if (m_ctrl[1]) begin
          if (lo == m_cmp[7:0]) set[3] = 1'b1;
          if (lo == 8'hFF) begin nl = m_rcap[7:0]; set[2] = 1'b1; end
          else nl = lo + 8'd1;
        end
        nc = {nh, nl};
      end
      if (reg_wr && reg_addr == 3'd1) m_stat <= (m_stat & reg_wdata[3:0]) | set;
      else m_stat <= m_stat | set;
      m_cnt  <= (reg_wr && reg_addr == 3'd2) ? reg_wdata : nc;
      m_rcap <= (reg_wr && reg_addr == 3'd3) ? reg_wdata : nr;
      if (reg_wr && reg_addr == 3'd0) m_ctrl <= reg_wdata[7:0];
      if (reg_wr && reg_addr == 3'd4) m_cmp <= reg_wdata;
      m_s1 <= pin_in; m_s2 <= m_s1; m_s3 <= m_s2;
    end
  end

  function automatic logic [15:0] m_read(input logic [2:0] a);
    case (a)
      3'd0: return {8'h00, m_ctrl};
      3'd1: return {12'h000, m_stat};
      3'd2: return m_cnt;
      3'd3: return m_rcap;
      3'd4: return m_cmp;
      default: return 16'h0000;
    endcase
  endfunction

  task automatic check(input bit ok, input string req, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
    end
  endtask

  // per-cycle comparison against the model, away from the edge
  always begin
    @(posedge clk);
    #1;
    if (rst_n && !done) begin
      check(reg_rdata == m_read(reg_addr), phase, reg_rdata, m_read(reg_addr));
      check(irq == (m_ctrl[6] && (m_stat != 0)), "R11", {15'd0, irq},
            {15'd0, m_ctrl[6] && (m_stat != 0)});
    end
  end

  task automatic wr(input logic [2:0] a, input logic [15:0] d);
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0; reg_addr = 3'd2;
  endtask

  task automatic rd(input logic [2:0] a, input logic [15:0] exp, input string req);
    @(negedge clk);
    reg_addr = a;
    @(posedge clk);
    #1;
    check(reg_rdata == exp, req, reg_rdata, exp);
    @(negedge clk);
    reg_addr = 3'd2;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic pulse(input int hi_len, input int lo_len);
    @(negedge clk); pin_in = 1'b1;
    idle(hi_len);
    pin_in = 1'b0;
    idle(lo_len);
  endtask

  initial begin
    idle(3);
    rst_n = 1'b1;
    // R1 reset values
    phase = "R1";
    rd(3'd0, 16'h0000, "R1"); rd(3'd1, 16'h0000, "R1");
    rd(3'd2, 16'h0000, "R1"); rd(3'd3, 16'h0000, "R1");
    rd(3'd4, 16'h0000, "R1");
    wr(3'd0, 16'hFF00);
    rd(3'd0, 16'h0000, "R1");
    // R7 counter mode, rising edges
    phase = "R7";
    wr(3'd0, 16'h000D);
    for (int i = 0; i < 4; i++) pulse(3, 3);
    idle(4);
    rd(3'd2, 16'h0004, "R7");
    // R2 both edges
    phase = "R2";
    wr(3'd0, 16'h001D);
    for (int i = 0; i < 3; i++) pulse(2, 2);
    idle(4);
    rd(3'd2, 16'h000A, "R2");
    // R2 falling only
    wr(3'd0, 16'h0015);
    for (int i = 0; i < 2; i++) pulse(4, 1);
    idle(4);
    rd(3'd2, 16'h000C, "R2");
    // R8 disabled counter mode
    phase = "R8";
    wr(3'd0, 16'h0005);
    for (int i = 0; i < 3; i++) pulse(1, 2);
    idle(4);
    rd(3'd2, 16'h000C, "R8");
    // R3/R4 compare and overflow with interrupt
    phase = "R4";
    wr(3'd0, 16'h0000);
    wr(3'd2, 16'hFFF8);
    wr(3'd3, 16'h1234);
    wr(3'd4, 16'hFFFB);
    wr(3'd0, 16'h0041);
    idle(14);
    rd(3'd1, 16'h0003, "R3");
    phase = "R9";
    wr(3'd0, 16'h0040);
    idle(6);
    // R10 clear races and keeps
    phase = "R10";
    wr(3'd1, 16'h0002);
    rd(3'd1, 16'h0002, "R10");
    wr(3'd1, 16'h0000);
    rd(3'd1, 16'h0000, "R10");
    // R13 software write while running
    phase = "R13";
    wr(3'd4, 16'h0000);
    wr(3'd0, 16'h0001);
    wr(3'd2, 16'h0100);
    idle(3);
    wr(3'd3, 16'h5555);
    // R5 capture on rising edge
    phase = "R5";
    wr(3'd0, 16'h0009);
    pulse(3, 5);
    idle(3);
    pulse(2, 4);
    wr(3'd0, 16'h0000);
    rd(3'd1, 16'h0002, "R5");
    // R5 capture coinciding with overflow
    wr(3'd1, 16'h0000);
    wr(3'd3, 16'h0777);
    wr(3'd2, 16'hFFF9);
    wr(3'd0, 16'h0009);
    pulse(8, 2);
    wr(3'd0, 16'h0000);
    // R6 edge reload on falling edge
    phase = "R6";
    wr(3'd1, 16'h0000);
    wr(3'd3, 16'h0050);
    wr(3'd2, 16'h0000);
    wr(3'd0, 16'h0091);
    pulse(5, 6);
    pulse(2, 3);
    wr(3'd0, 16'h0000);
    // R12 split: low compare-only, high counts rising edges
    phase = "R12";
    wr(3'd1, 16'h0000);
    wr(3'd2, 16'h00F0);
    wr(3'd3, 16'h0010);
    wr(3'd4, 16'h00F5);
    wr(3'd0, 16'h002F);
    pulse(3, 3);
    pulse(3, 3);
    idle(20);
    wr(3'd0, 16'h002D);
    @(negedge clk); reg_addr = 3'd2;
    @(posedge clk); #1;
    check(reg_rdata[15:8] == 8'h02, "R12", reg_rdata, 16'h0200);
    rd(3'd1, 16'h000C, "R12");
    // R12 split high half in compare mode, pin must not touch low byte
    wr(3'd0, 16'h0021);
    pulse(2, 2);
    wr(3'd0, 16'h0061);
    idle(8);
    phase = "R9";
    wr(3'd0, 16'h0000);
    idle(5);
    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #(4 * 100000);
    if (!done) begin
      done = 1'b1;
      checks++;
      errors++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule